// File: doc/BRIEF.md
# Sixteen-bit register-operand ALU with dual overflow flags

This block is the purely combinational arithmetic and logic unit for register-to-register operations in a small 16-bit processor. Two operands and a 3-bit function select go in; a 16-bit result and two overflow indications come out in the same cycle, with no clock and no internal state.

The function select covers bitwise OR and AND, addition, subtraction, three shifts whose distance comes from the second operand, and a signed less-than comparison. Code 0 is OR, so an instruction word of all zeros writes zero OR zero back and behaves as a no-op. Overflow is reported twice: once for the signed (two's-complement) reading of an add or subtract, and once for the unsigned reading (carry out or borrow). Both flags are combinational and are not held between operations.

Top module: `alu_rtype`

## Requirements
- R1: Code 0 yields A OR B and code 1 yields A AND B; with A, B and the code all zero the result and both flags are zero.
- R2: Code 2 yields A + B modulo 2^16.
- R3: Code 3 yields A - B modulo 2^16.
- R4: Code 4 shifts A left by B[3:0], filling with zeros; B[15:4] has no effect on any shift.
- R5: Code 5 shifts A right by B[3:0], filling the vacated upper bits with zeros.
- R6: Code 6 shifts A right by B[3:0], filling the vacated upper bits with copies of A[15].
- R7: Code 7 yields 1 in bit 0 when A is less than B as two's-complement values and 0 otherwise; bits 15:1 are always zero.
- R8: The signed overflow flag is 1 on code 2 when A and B share a sign that the sum does not, and on code 3 when A and B differ in sign and the difference's sign differs from A.
- R9: The unsigned overflow flag is 1 on code 2 when A + B exceeds 65535, and on code 3 when A is less than B as unsigned values.
- R10: For codes 0, 1, 4, 5, 6 and 7 both overflow flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 16 | First operand A; shifted value for the shift codes |
| opb | input | 16 | Second operand B; low 4 bits are the shift distance |
| fsel | input | 3 | Function select, 0 to 7 as listed in the requirements |
| res | output | 16 | Operation result |
| ovf_signed | output | 1 | Two's-complement overflow of add or subtract |
| ovf_unsigned | output | 1 | Carry out of add or borrow of subtract |

## Verification
Every output of this block is due in the same cycle its operands and function select are applied, with zero register stages on any path. The bench drives a new operand set on the rising clock edge and compares the result and both flags at the following falling edge, half a period later, so each comparison sees settled values of that one stimulus. Directed vectors cover shift distances 0 and 15, ignored upper shift bits, sign-boundary sums and differences, and the all-zero no-op; a seeded random run sweeps all eight codes.

// File: rtl/alu_rtype.sv
module alu_rtype #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       fsel,
  output logic [WIDTH-1:0] res,
  output logic             ovf_signed,
  output logic             ovf_unsigned
);
  localparam int SHW = $clog2(WIDTH);
  localparam int MSB = WIDTH - 1;

  typedef enum logic [2:0] {
    F_OR  = 3'd0,
    F_AND = 3'd1,
    F_ADD = 3'd2,
    F_SUB = 3'd3,
    F_SHL = 3'd4,
    F_SHR = 3'd5,
    F_SAR = 3'd6,
    F_SLT = 3'd7
  } func_e;

  logic [SHW-1:0] shamt;
  logic [WIDTH:0] sum_ext;
  logic [WIDTH:0] dif_ext;
  logic           less_s;

  assign shamt   = opb[SHW-1:0];
  assign sum_ext = {1'b0, opa} + {1'b0, opb};
  assign dif_ext = {1'b0, opa} - {1'b0, opb};
  assign less_s  = $signed(opa) < $signed(opb);

  always_comb begin
    res          = '0;
    ovf_signed   = 1'b0;
    ovf_unsigned = 1'b0;
    case (func_e'(fsel))
      F_OR:  res = opa | opb;
      F_AND: res = opa & opb;
      F_ADD: begin
        res          = sum_ext[MSB:0];
        ovf_unsigned = sum_ext[WIDTH];
        ovf_signed   = (opa[MSB] == opb[MSB]) && (sum_ext[MSB] != opa[MSB]);
      end
      F_SUB: begin
        res          = dif_ext[MSB:0];
        ovf_unsigned = dif_ext[WIDTH];
        ovf_signed   = (opa[MSB] != opb[MSB]) && (dif_ext[MSB] != opa[MSB]);
      end
      F_SHL: res = opa << shamt;
      F_SHR: res = opa >> shamt;
      F_SAR: res = $unsigned($signed(opa) >>> shamt);
      F_SLT: res = {{(WIDTH-1){1'b0}}, less_s};
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu_rtype_chk.sv
module alu_rtype_chk #(
  parameter int WIDTH = 16
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       fsel,
  input logic [WIDTH-1:0] res,
  input logic             ovf_signed,
  input logic             ovf_unsigned
);
  localparam int SHW = $clog2(WIDTH);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    // R10
    a_r10_flags_quiet: assert (!(fsel != 3'd2 && fsel != 3'd3) || (!ovf_signed && !ovf_unsigned))
      else $error("flags raised outside add/sub");
    // R7
    a_r7_slt_upper_zero: assert (fsel != 3'd7 || res[MSB:1] == '0)
      else $error("slt upper bits nonzero");
    // R9
    a_r9_borrow: assert (fsel != 3'd3 || ovf_unsigned == (opa < opb))
      else $error("borrow flag wrong");
    // R6
    a_r6_sign_kept: assert (fsel != 3'd6 || res[MSB] == opa[MSB])
      else $error("arith shift lost sign");
    // R5
    a_r5_zero_fill: assert (fsel != 3'd5 || opb[SHW-1:0] == '0 || !res[MSB])
      else $error("logical shift filled ones");
    // R8
    a_r8_sign_flip: assert (!(fsel == 3'd2 && ovf_signed) || res[MSB] != opa[MSB])
      else $error("signed overflow without sign flip");
    // R1
    a_r1_nop: assert (!(fsel == 3'd0 && opa == '0 && opb == '0) || res == '0)
      else $error("all-zero op not a no-op");
  end
endmodule

bind alu_rtype alu_rtype_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/test_alu_rtype.sv
`timescale 1ns/1ps
module test_alu_rtype;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] opa = '0, opb = '0;
  logic [2:0]  fsel = '0;
  logic [15:0] res;
  logic        ovf_signed, ovf_unsigned;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  alu_rtype i_alu_rtype (.opa(opa), .opb(opb), .fsel(fsel), .res(res),
                         .ovf_signed(ovf_signed), .ovf_unsigned(ovf_unsigned));

  function automatic logic [15:0] m_res(logic [2:0] f, logic [15:0] a, logic [15:0] b);
    int t;
    int n = int'(b[3:0]);
    logic [15:0] r = a;
    case (f)
      3'd0: return a | b;
      3'd1: return a & b;
      3'd2: begin t = int'(a) + int'(b); return t[15:0]; end
      3'd3: begin t = int'(a) - int'(b); return t[15:0]; end
      3'd4: begin for (int i = 0; i < n; i++) r = {r[14:0], 1'b0}; return r; end
      3'd5: begin for (int i = 0; i < n; i++) r = {1'b0, r[15:1]}; return r; end
      3'd6: begin for (int i = 0; i < n; i++) r = {r[15], r[15:1]}; return r; end
      default: return (int'($signed(a)) < int'($signed(b))) ? 16'd1 : 16'd0;
    endcase
  endfunction

  function automatic logic m_sov(logic [2:0] f, logic [15:0] a, logic [15:0] b);
    int s;
    if (f == 3'd2) s = int'($signed(a)) + int'($signed(b));
    else if (f == 3'd3) s = int'($signed(a)) - int'($signed(b));
    else return 1'b0;
    return (s > 32767) || (s < -32768);
  endfunction

  function automatic logic m_uov(logic [2:0] f, logic [15:0] a, logic [15:0] b);
    if (f == 3'd2) return (int'(a) + int'(b)) > 65535;
    if (f == 3'd3) return int'(a) < int'(b);
    return 1'b0;
  endfunction

  function automatic string tag_of(logic [2:0] f);
    case (f)
      3'd0, 3'd1: return "R1";
      3'd2: return "R2";
      3'd3: return "R3";
      3'd4: return "R4";
      3'd5: return "R5";
      3'd6: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] f, logic [15:0] a, logic [15:0] b, string tag);
    string ftag;
    @(posedge clk);
    fsel = f; opa = a; opb = b;
    @(negedge clk);
    cmp(tag, "res", res, m_res(f, a, b));
    ftag = (f == 3'd2 || f == 3'd3) ? "R8" : "R10";
    cmp(ftag, "ovf_signed", {15'd0, ovf_signed}, {15'd0, m_sov(f, a, b)});
    ftag = (f == 3'd2 || f == 3'd3) ? "R9" : "R10";
    cmp(ftag, "ovf_unsigned", {15'd0, ovf_unsigned}, {15'd0, m_uov(f, a, b)});
  endtask

  initial begin
    logic [15:0] keep;
    void'($urandom(32'h5eed_1234));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cmp("R1", "reset no-op res", res, 16'h0000);
    cmp("R10", "reset flags", {14'd0, ovf_signed, ovf_unsigned}, 16'h0000);

    apply(3'd0, 16'h0000, 16'h0000, "R1");
    apply(3'd0, 16'hF0F0, 16'h0FF0, "R1");
    apply(3'd1, 16'hF0F0, 16'h0FF0, "R1");
    apply(3'd2, 16'h7FFF, 16'h0001, "R2");
    apply(3'd2, 16'hFFFF, 16'h0001, "R2");
    apply(3'd2, 16'h8000, 16'h8000, "R2");
    apply(3'd3, 16'h0000, 16'h0001, "R3");
    apply(3'd3, 16'h8000, 16'h0001, "R3");
    apply(3'd3, 16'h7FFF, 16'hFFFF, "R3");
    apply(3'd3, 16'h1234, 16'h1234, "R3");
    apply(3'd4, 16'h8001, 16'h000F, "R4");
    apply(3'd4, 16'h00FF, 16'h0000, "R4");
    apply(3'd4, 16'h00FF, 16'hFFF3, "R4");
    // R4: B upper bits ignored -> same as shift by 3
    apply(3'd4, 16'h00FF, 16'h0003, "R4");
    keep = res;
    apply(3'd4, 16'h00FF, 16'hABC3, "R4");
    cmp("R4", "upper B ignored", res, keep);
    apply(3'd5, 16'h8000, 16'h000F, "R5");
    apply(3'd5, 16'hF00F, 16'h0004, "R5");
    apply(3'd6, 16'h8000, 16'h000F, "R6");
    apply(3'd6, 16'h7000, 16'h000F, "R6");
    apply(3'd6, 16'hF00F, 16'hFFF4, "R6");
    apply(3'd7, 16'hFFFF, 16'h0001, "R7");
    apply(3'd7, 16'h0001, 16'hFFFF, "R7");
    apply(3'd7, 16'h8000, 16'h7FFF, "R7");
    apply(3'd7, 16'h1234, 16'h1234, "R7");

    for (int k = 0; k < 4000; k++) begin
      logic [2:0] f = 3'(k % 8);
      logic [15:0] a = 16'($urandom);
      logic [15:0] b = 16'($urandom);
      apply(f, a, b, tag_of(f));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule